// File: doc/BRIEF.md
# Handshake Count Synchronizer

This block carries a multi-bit binary count from a source clock domain into a destination clock domain that runs on an unrelated clock. It does not use Gray coding. The source side copies the live count into a holding register and raises a request line. It then keeps that copy frozen for the rest of the exchange. The request passes through a two-flop synchronizer into the destination domain. There, the first cycle in which it is seen high captures the frozen copy, produces a one-cycle valid pulse and raises an acknowledge.

The acknowledge is synchronized back into the source domain. When it arrives, the source drops its request. The destination keeps acknowledge high until it sees the request low, then clears it. Once the source sees acknowledge low again, the four-phase exchange is complete and the next sample is taken at once.

Any count values that occur while an exchange is in flight are never sent. The receiver gets a stream of periodic snapshots. Each snapshot is whole and consistent, even when many bits of the counter change at the same moment.

Top module: `cnt_handshake_xfer`

## Requirements
- R1: While reset is applied, and after reset until the first transfer, `dst_count` is zero and `dst_valid` is low.
- R2: While the request is high, the held sample in the source domain does not change.
- R3: A new request is raised only while the acknowledge, as seen in the source domain, is low.
- R4: `dst_valid` is high for exactly one destination cycle per transfer. `dst_count` takes the transferred value in that same cycle, and acknowledge is high in that cycle.
- R5: Every value delivered on `dst_count` is a value that `src_count` actually carried on some source clock edge, with all bits intact. This holds across a carry that flips many bits at once (0x7FFF to 0x8000).
- R6: When the input count never decreases, delivered values never decrease. Values that occur between samples are skipped, so consecutive deliveries of a count that steps by one every cycle may differ by more than one.
- R7: The destination acknowledge, once raised, stays high until the synchronized request has been seen low. It falls only after such a cycle.
- R8: Between valid pulses, `dst_count` holds its value.
- R9: Transfers repeat without stalling for any ratio of the two clocks. A steady stream of samples keeps arriving, including the values after a many-bit carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source domain clock |
| src_rst_n | input | 1 | Source domain asynchronous active-low reset |
| src_count | input | CNT_W | Live binary count in the source domain |
| dst_clk | input | 1 | Destination domain clock |
| dst_rst_n | input | 1 | Destination domain asynchronous active-low reset |
| dst_count | output | CNT_W | Most recently transferred count sample |
| dst_valid | output | 1 | One-cycle pulse marking a new sample on dst_count |

## Verification
Two things can fall on the same source edge: the source takes its sample, and the count input goes through a carry that flips most of its bits. On the destination side, capture of the held value can happen while the source counter is still racing ahead. The bench provokes both by running the count through 0x7FFF to 0x8000, and by stepping it every cycle at three different destination clock periods. Every captured value is judged against the queue of values the driver actually applied. It must match one of them exactly and must not be lower than the value delivered before it.

// File: rtl/hsx_pkg.sv
package hsx_pkg;
  typedef enum logic [1:0] {
    SRC_SAMPLE   = 2'd0,
    SRC_WAIT_ACK = 2'd1,
    SRC_WAIT_REL = 2'd2
  } src_state_e;
endpackage

// File: rtl/hsx_rst_sync.sv
module hsx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n = chain_q[STAGES-1];
endmodule

// File: rtl/hsx_sync.sv
module hsx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stage_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[0] <= 1'b0;
          else        stage_q[0] <= d_i;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[i] <= 1'b0;
          else        stage_q[i] <= stage_q[i-1];
        end
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/hsx_src.sv
module hsx_src
  import hsx_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count_i,
  input  logic             ack_sync_i,
  output logic             req_o,
  output logic [CNT_W-1:0] hold_o
);
  src_state_e       state_q, state_n;
  logic             req_q, req_n;
  logic [CNT_W-1:0] hold_q;
  logic             hold_en;

  always_comb begin
    state_n = state_q;
    req_n   = req_q;
    hold_en = 1'b0;
    case (state_q)
      SRC_SAMPLE: begin
        hold_en = 1'b1;
        req_n   = 1'b1;
        state_n = SRC_WAIT_ACK;
      end
      SRC_WAIT_ACK: begin
        if (ack_sync_i) begin
          req_n   = 1'b0;
          state_n = SRC_WAIT_REL;
        end
      end
      SRC_WAIT_REL: begin
        if (!ack_sync_i) state_n = SRC_SAMPLE;
      end
      default: begin
        req_n   = 1'b0;
        state_n = SRC_SAMPLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SRC_SAMPLE;
      req_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      req_q   <= req_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= '0;
    else if (hold_en) hold_q <= count_i;
  end

  assign req_o  = req_q;
  assign hold_o = hold_q;
endmodule

// File: rtl/hsx_dst.sv
module hsx_dst #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_sync_i,
  input  logic [CNT_W-1:0] hold_i,
  output logic             ack_o,
  output logic [CNT_W-1:0] count_o,
  output logic             valid_o
);
  logic             ack_q, ack_n;
  logic             valid_q;
  logic [CNT_W-1:0] count_q;
  logic             cap_en;

  always_comb begin
    cap_en = req_sync_i && !ack_q;
    ack_n  = ack_q;
    if (cap_en)           ack_n = 1'b1;
    else if (!req_sync_i) ack_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q   <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      ack_q   <= ack_n;
      valid_q <= cap_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count_q <= '0;
    else if (cap_en) count_q <= hold_i;
  end

  assign ack_o   = ack_q;
  assign count_o = count_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/cnt_handshake_xfer.sv
module cnt_handshake_xfer #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             src_clk,
  input  logic             src_rst_n,
  input  logic [CNT_W-1:0] src_count,
  input  logic             dst_clk,
  input  logic             dst_rst_n,
  output logic [CNT_W-1:0] dst_count,
  output logic             dst_valid
);
  logic             srst_n, drst_n;
  logic             src_req, src_ack_sync;
  logic [CNT_W-1:0] src_hold;
  logic             dst_req_sync, dst_ack;

  hsx_rst_sync #(.STAGES(SYNC_STAGES)) u_srst (
    .clk(src_clk), .arst_n(src_rst_n), .rst_n(srst_n));
  hsx_rst_sync #(.STAGES(SYNC_STAGES)) u_drst (
    .clk(dst_clk), .arst_n(dst_rst_n), .rst_n(drst_n));

  hsx_src #(.CNT_W(CNT_W)) u_src (
    .clk(src_clk), .rst_n(srst_n), .count_i(src_count),
    .ack_sync_i(src_ack_sync), .req_o(src_req), .hold_o(src_hold));

  hsx_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk(dst_clk), .rst_n(drst_n), .d_i(src_req), .q_o(dst_req_sync));

  hsx_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(src_clk), .rst_n(srst_n), .d_i(dst_ack), .q_o(src_ack_sync));

  hsx_dst #(.CNT_W(CNT_W)) u_dst (
    .clk(dst_clk), .rst_n(drst_n), .req_sync_i(dst_req_sync),
    .hold_i(src_hold), .ack_o(dst_ack), .count_o(dst_count),
    .valid_o(dst_valid));
endmodule

// File: rtl/hsx_checker.sv
module hsx_checker #(
  parameter int CNT_W = 16
) (
  input logic             src_clk,
  input logic             srst_n,
  input logic             src_req,
  input logic             src_ack_sync,
  input logic [CNT_W-1:0] src_hold,
  input logic             dst_clk,
  input logic             drst_n,
  input logic             dst_req_sync,
  input logic             dst_ack,
  input logic             dst_valid,
  input logic [CNT_W-1:0] dst_count
);
  // R2
  hold_frozen_chk: assert property (@(posedge src_clk) disable iff (!srst_n)
    (src_req && $past(src_req)) |-> $stable(src_hold));

  // R3
  req_rise_gated_chk: assert property (@(posedge src_clk) disable iff (!srst_n)
    $rose(src_req) |-> !src_ack_sync);

  // R4
  valid_single_chk: assert property (@(posedge dst_clk) disable iff (!drst_n)
    dst_valid |=> !dst_valid);

  // R4
  valid_with_ack_chk: assert property (@(posedge dst_clk) disable iff (!drst_n)
    dst_valid |-> dst_ack);

  // R7
  ack_hold_chk: assert property (@(posedge dst_clk) disable iff (!drst_n)
    (dst_ack && dst_req_sync) |=> dst_ack);

  // R7
  ack_release_chk: assert property (@(posedge dst_clk) disable iff (!drst_n)
    $fell(dst_ack) |-> $past(!dst_req_sync));

  // R8
  count_hold_chk: assert property (@(posedge dst_clk) disable iff (!drst_n)
    !$stable(dst_count) |-> dst_valid);
endmodule

bind cnt_handshake_xfer hsx_checker #(.CNT_W(CNT_W)) u_chk (
  .src_clk(src_clk), .srst_n(srst_n), .src_req(src_req),
  .src_ack_sync(src_ack_sync), .src_hold(src_hold),
  .dst_clk(dst_clk), .drst_n(drst_n), .dst_req_sync(dst_req_sync),
  .dst_ack(dst_ack), .dst_valid(dst_valid), .dst_count(dst_count));

// File: tb/cnt_handshake_xfer_tb_top.sv
`timescale 1ns/1ps
module cnt_handshake_xfer_tb_top;
  localparam int CNT_W = 16;

  logic             src_clk = 1'b0;
  logic             dst_clk = 1'b0;
  logic             src_rst_n = 1'b0;
  logic             dst_rst_n = 1'b0;
  logic [CNT_W-1:0] src_count = '0;
  logic [CNT_W-1:0] dst_count;
  logic             dst_valid;
  realtime          dst_half = 7.0;

  int               vectors = 0;
  int               errors = 0;
  int               deliveries = 0;
  int               valid_run = 0;
  int               max_gap = 0;
  bit               mon_en = 1'b0;
  bit               have_last = 1'b0;
  bit               done = 1'b0;
  logic [CNT_W-1:0] last_v = '0;
  logic [CNT_W-1:0] expq[$];

  cnt_handshake_xfer #(.CNT_W(CNT_W), .SYNC_STAGES(2)) dut_i (
    .src_clk(src_clk), .src_rst_n(src_rst_n), .src_count(src_count),
    .dst_clk(dst_clk), .dst_rst_n(dst_rst_n),
    .dst_count(dst_count), .dst_valid(dst_valid));

  always #5 src_clk = ~src_clk;
  always #(dst_half) dst_clk = ~dst_clk;

  task automatic chk(input bit ok, input string req,
                     input logic [CNT_W-1:0] act, input logic [CNT_W-1:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input int step, input int n);
    for (int i = 0; i < n; i++) begin
      logic [CNT_W-1:0] nv;
      @(negedge src_clk);
      nv = src_count + CNT_W'(step);
      src_count = nv;
      expq.push_back(nv);
    end
  endtask

  // scoreboard monitor
  always @(negedge dst_clk) begin
    if (mon_en) begin
      if (dst_valid) begin
        valid_run++;
        deliveries++;
        // R4: pulse is one cycle wide
        chk(valid_run == 1, "R4", CNT_W'(valid_run), CNT_W'(1));
        // R5: value must be one that was applied
        while (expq.size() > 0 && expq[0] != dst_count) void'(expq.pop_front());
        chk(expq.size() > 0, "R5", dst_count, src_count);
        // R6: never decreasing
        if (have_last) begin
          chk(dst_count >= last_v, "R6", dst_count, last_v);
          if (int'(dst_count) - int'(last_v) > max_gap)
            max_gap = int'(dst_count) - int'(last_v);
        end
        last_v    = dst_count;
        have_last = 1'b1;
      end else begin
        valid_run = 0;
        // R8: value held between pulses
        if (have_last) chk(dst_count == last_v, "R8", dst_count, last_v);
      end
    end
  end

  initial begin
    #500000;
    if (!done) begin
      errors++;
      vectors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    int d0;
    expq.push_back('0);
    repeat (5) @(negedge src_clk);
    // R1: reset state
    chk(dst_count == '0, "R1", dst_count, '0);
    chk(dst_valid == 1'b0, "R1", CNT_W'(dst_valid), '0);
    src_rst_n = 1'b1;
    dst_rst_n = 1'b1;
    @(negedge dst_clk);
    chk(dst_count == '0, "R1", dst_count, '0);
    chk(dst_valid == 1'b0, "R1", CNT_W'(dst_valid), '0);
    mon_en = 1'b1;

    // phase A: step every cycle, destination near source rate
    d0 = deliveries;
    drive(1, 800);
    // R9
    chk(deliveries - d0 >= 15, "R9", CNT_W'(deliveries - d0), CNT_W'(15));
    // R6: intermediate values skipped
    chk(max_gap > 1, "R6", CNT_W'(max_gap), CNT_W'(2));

    // phase B: constant count, slow destination
    dst_half = 23.0;
    d0 = deliveries;
    drive(0, 800);
    // R9
    chk(deliveries - d0 >= 8, "R9", CNT_W'(deliveries - d0), CNT_W'(8));

    // phase C: many-bit carry, fast destination
    dst_half = 3.0;
    @(negedge src_clk);
    src_count = 16'h7FF0;
    expq.push_back(16'h7FF0);
    drive(1, 40);
    drive(3, 600);
    repeat (60) @(negedge src_clk);
    // R9, R5: values past the carry arrive intact
    chk(last_v >= 16'h8000, "R9", last_v, 16'h8000);
    chk(deliveries > 0, "R5", CNT_W'(deliveries), CNT_W'(1));

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule